// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block models the read side of a one-bit-wide configuration memory that feeds an FPGA loading itself from a serial bitstream. Each clock edge that finds the device enabled moves an internal bit pointer forward by one and presents the next stored bit on a tri-stateable data output. The output is modelled as a value plus a drive-enable. The memory array is a small register array that is filled with a computed pattern during reset.

A reset/output-enable input clears the pointer. Its active level is fixed per instance by a configuration bit, so either polarity of the FPGA's reset signal can drive it directly. Several devices can share one data line. A device that has delivered its last bit stops driving the line and pulls its chain-enable output low. That output feeds the chip enable of the next device, which then continues the stream without a gap.

An open-drain ready output is pulled low for a fixed power-on interval after reset. During that interval the device neither reads nor drives. Pulling the serial-enable input low puts the device in programming mode, which suspends the read logic and leaves its state intact.

Top module: `sercfg_rom`

## Requirements
- R1: Stream bit n is bit (WORD_W-1 - n mod WORD_W) of word n/WORD_W, so each word is read most significant bit first. Word k holds (k*37 + SEED) mod 2^WORD_W. Bit 0 is presented before the first advancing edge, and each advancing edge presents the next bit.
- R2: data_oe is 1 only when all of the following hold: ready_low is 0, ser_en is 1, ce_n is 0, rst_oe is at its enable level, and the last bit has not yet been consumed. In every other case data_oe is 0 (high impedance).
- R3: A clock edge that sees rst_oe at its reset level clears the pointer and the end-of-memory state, whatever ce_n is. The next read then starts at bit 0. While rst_oe is at the reset level, data_oe is 0.
- R4: With RST_HIGH=1 the reset level of rst_oe is 1. With RST_HIGH=0 it is 0. The opposite level is the enable level.
- R5: While ce_n is 1, the pointer is frozen and data_oe is 0. When ce_n returns to 0, the stream resumes at the next unread bit.
- R6: The enabled edge that follows the presentation of bit DEPTH_BITS-1 makes ceo_n go to 0 and data_oe go to 0 together. After that edge the pointer holds its value.
- R7: Once the last bit has been consumed, ceo_n follows ce_n as long as rst_oe stays at its enable level. ceo_n goes to 1 as soon as rst_oe takes its reset level. It then stays at 1 until the whole memory has been read again.
- R8: ready_low is 1 from reset until POR_CYCLES clock edges after rst falls, and 0 from then until the next reset. While ready_low is 1, nothing advances, data_oe is 0 and ceo_n is 1.
- R9: While ser_en is 0, data_oe is 0 and ceo_n is 1. The pointer holds its value even if rst_oe is at its reset level. After ser_en returns to 1, the stream continues from the bit that was pending.
- R10: Two devices chained with ceo_n to ce_n deliver one contiguous stream of 2*DEPTH_BITS bits on a shared line. The first device supplies the first half and the second device the second half. At no point do both devices drive the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; every rising edge may advance the read |
| rst | input | 1 | Synchronous active-high reset; fills the array and starts the power-on interval |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Reset / output-enable input; its reset level is set by RST_HIGH |
| ser_en | input | 1 | 1 selects serial read, 0 selects programming mode (read suspended) |
| data_o | output | 1 | Currently presented stream bit |
| data_oe | output | 1 | Drive enable for data_o; 0 means high impedance |
| ceo_n | output | 1 | Chain enable out, active low, for the next device's ce_n |
| ready_low | output | 1 | Open-drain pull-down enable; 1 while the power-on interval runs |

## Verification
The data register is loaded with the bit at the next pointer value on every edge. As a result, the bit for stream position n is visible in the cycle just after the n-th advancing edge. data_oe and ceo_n respond combinationally to ce_n, rst_oe and ser_en within the same cycle. ready_low is released on exactly the POR_CYCLES-th edge after rst falls. The bench changes inputs 2 ns after a falling edge and samples 1 ns later. Every expected value is therefore read in the cycle the rules above assign to it, with both chained devices and the resolved shared line observed together.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  // Fill pattern for word k; callers truncate to their word width.
  function automatic logic [31:0] fill_word(input int unsigned k, input int unsigned seed);
    return 32'(k * 37 + seed);
  endfunction
endpackage

// File: rtl/sercfg_por.sv
module sercfg_por #(
  parameter int POR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic hold
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (hold) begin
      if (cnt == CW'(POR_CYCLES - 1)) hold <= 1'b0;
      else                            cnt  <= cnt + 1'b1;
    end
  end

  // R8
  ready_stays_chk: assert property (@(posedge clk) disable iff (rst) !hold |=> !hold);
endmodule

// File: rtl/sercfg_array.sv
module sercfg_array #(
  parameter int WORD_W     = 8,
  parameter int DEPTH_BITS = 1024,
  parameter int SEED       = 17
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(DEPTH_BITS)-1:0] rd_ptr,
  output logic                          rd_bit
);
  import sercfg_pkg::*;
  localparam int N_WORDS = DEPTH_BITS / WORD_W;
  localparam int AW      = $clog2(DEPTH_BITS);
  localparam int WB      = $clog2(WORD_W);

  logic [WORD_W-1:0] mem [N_WORDS];
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_WORDS; i++)
        mem[i] <= WORD_W'(fill_word(i, SEED));
    end
  end

  // Most significant bit first: bit offset b maps to index WORD_W-1-b.
  always_comb begin
    word   = mem[rd_ptr[AW-1:WB]];
    rd_bit = word[~rd_ptr[WB-1:0]];
  end
endmodule

// File: rtl/sercfg_seq.sv
module sercfg_seq #(
  parameter int DEPTH_BITS = 1024,
  parameter bit RST_HIGH   = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ready,
  input  logic                          ser_en,
  input  logic                          ce_n,
  input  logic                          rst_oe,
  output logic [$clog2(DEPTH_BITS)-1:0] ptr,
  output logic [$clog2(DEPTH_BITS)-1:0] ptr_d,
  output logic                          done,
  output logic                          data_oe,
  output logic                          ceo_n
);
  localparam int            AW   = $clog2(DEPTH_BITS);
  localparam logic [AW-1:0] LAST = AW'(DEPTH_BITS - 1);

  logic active, rst_lvl, rst_hit, adv, done_d;

  always_comb begin
    active  = ready & ser_en;
    rst_lvl = (rst_oe == RST_HIGH);
    rst_hit = active & rst_lvl;
    adv     = active & ~rst_lvl & ~ce_n & ~done;
    ptr_d   = ptr;
    done_d  = done;
    if (rst_hit) begin
      ptr_d  = '0;
      done_d = 1'b0;
    end else if (adv) begin
      if (ptr == LAST) done_d = 1'b1;
      else             ptr_d  = ptr + 1'b1;
    end
    data_oe = active & ~ce_n & ~rst_lvl & ~done;
    ceo_n   = ~(active & done & ~ce_n & ~rst_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      done <= 1'b0;
    end else begin
      ptr  <= ptr_d;
      done <= done_d;
    end
  end

  // R3
  clear_on_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && ser_en && (rst_oe == RST_HIGH)) |=> (ptr == '0) && !done);
  // R5
  standby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && ser_en && ce_n && (rst_oe != RST_HIGH)) |=> (ptr == $past(ptr)));
  // R9
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !ser_en) |=> (ptr == $past(ptr)) && (done == $past(done)));
  // R6
  last_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(ptr) == LAST));
endmodule

// File: rtl/sercfg_rom.sv
module sercfg_rom #(
  parameter int WORD_W     = 8,
  parameter int DEPTH_BITS = 1024,
  parameter int SEED       = 17,
  parameter int POR_CYCLES = 16,
  parameter bit RST_HIGH   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic rst_oe,
  input  logic ser_en,
  output logic data_o,
  output logic data_oe,
  output logic ceo_n,
  output logic ready_low
);
  localparam int AW = $clog2(DEPTH_BITS);

  logic [AW-1:0] ptr, ptr_d;
  logic          done, rd_bit, data_q;

  sercfg_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .hold(ready_low)
  );

  sercfg_seq #(.DEPTH_BITS(DEPTH_BITS), .RST_HIGH(RST_HIGH)) u_seq (
    .clk(clk), .rst(rst), .ready(~ready_low), .ser_en(ser_en), .ce_n(ce_n),
    .rst_oe(rst_oe), .ptr(ptr), .ptr_d(ptr_d), .done(done),
    .data_oe(data_oe), .ceo_n(ceo_n)
  );

  sercfg_array #(.WORD_W(WORD_W), .DEPTH_BITS(DEPTH_BITS), .SEED(SEED)) u_array (
    .clk(clk), .rst(rst), .rd_ptr(ptr_d), .rd_bit(rd_bit)
  );

  // Prefetch: the register always holds the bit at the pointer's next value.
  always_ff @(posedge clk) begin
    if (rst) data_q <= 1'b0;
    else     data_q <= rd_bit;
  end

  assign data_o = data_q;

  // R1
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + 1'b1) || (ptr == '0)));
  // R8
  quiet_in_por_chk: assert property (@(posedge clk) disable iff (rst)
    ready_low |-> (!data_oe && ceo_n));
  // R7
  ceo_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    !ceo_n |-> done);
endmodule

// File: tb/sercfg_rom_bench.sv
`timescale 1ns/1ps
module sercfg_rom_bench;
  localparam int WORD_W = 8;
  localparam int DEPTH  = 128;
  localparam int POR    = 8;
  localparam int SEED_A = 17;
  localparam int SEED_B = 90;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1;
  logic oe_line = 1'b0;
  logic ser_en = 1'b1;
  logic a_d, a_oe, a_ceo, a_rdy, b_d, b_oe, b_ceo, b_rdy, bus;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  // Device A resets on a high level, device B on a low level of its input.
  sercfg_rom #(.WORD_W(WORD_W), .DEPTH_BITS(DEPTH), .SEED(SEED_A),
               .POR_CYCLES(POR), .RST_HIGH(1'b1)) u_sercfg_rom (
    .clk(clk), .rst(rst), .ce_n(ce_n), .rst_oe(oe_line), .ser_en(ser_en),
    .data_o(a_d), .data_oe(a_oe), .ceo_n(a_ceo), .ready_low(a_rdy));

  sercfg_rom #(.WORD_W(WORD_W), .DEPTH_BITS(DEPTH), .SEED(SEED_B),
               .POR_CYCLES(POR), .RST_HIGH(1'b0)) u_sercfg_rom_b (
    .clk(clk), .rst(rst), .ce_n(a_ceo), .rst_oe(~oe_line), .ser_en(ser_en),
    .data_o(b_d), .data_oe(b_oe), .ceo_n(b_ceo), .ready_low(b_rdy));

  assign bus = a_oe ? a_d : (b_oe ? b_d : 1'bz);

  function automatic logic exp_bit(input int seed, input int n);
    logic [7:0] w;
    w = 8'((n / WORD_W) * 37 + seed);
    return w[WORD_W - 1 - (n % WORD_W)];
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // who: 0 = A drives bit n, 1 = B drives bit n, 2 = nobody drives
  task automatic chk_line(input string req, input int who, input int n);
    logic e;
    e = (who == 0) ? exp_bit(SEED_A, n) : (who == 1) ? exp_bit(SEED_B, n) : 1'bz;
    chk(req, $sformatf("line who=%0d bit=%0d {a_oe,b_oe,bus}", who, n),
        {5'b0, a_oe, b_oe, bus}, {5'b0, (who == 0), (who == 1), e});
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic restart();
    oe_line = 1'b1;
    step();
    oe_line = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk("R8", "ready_low in reset", {6'b0, a_rdy, b_rdy}, 8'b11);
    chk("R2", "no drive in reset", {6'b0, a_oe, b_oe}, 8'b00);
    rst = 1'b0;
    ce_n = 1'b0;
    repeat (POR - 1) step();
    #1 chk("R8", "ready_low before end of interval", {6'b0, a_rdy, b_rdy}, 8'b11);
    chk("R8", "no drive during interval", {5'b0, a_oe, b_oe, a_ceo}, 8'b001);
    step();
    #1 chk("R8", "ready_low released", {6'b0, a_rdy, b_rdy}, 8'b00);
    ce_n = 1'b1;
  endtask

  task automatic t_chain();
    ce_n = 1'b0;
    restart();
    for (int n = 0; n < 2 * DEPTH; n++) begin
      #1;
      if (n < DEPTH) chk_line("R10", 0, n);
      else           chk_line("R10", 1, n - DEPTH);
      if (n == DEPTH - 1) chk("R6", "ceo_n before last edge", {7'b0, a_ceo}, 8'd1);
      if (n == DEPTH)     chk("R6", "ceo_n after last edge", {7'b0, a_ceo}, 8'd0);
      step();
    end
    #1 chk_line("R6", 2, 0);
    chk("R6", "both chain outputs low at end", {6'b0, a_ceo, b_ceo}, 8'b00);
  endtask

  task automatic t_follow();
    ce_n = 1'b1;
    #1 chk("R7", "ceo_n follows ce_n high", {7'b0, a_ceo}, 8'd1);
    step();
    ce_n = 1'b0;
    #1 chk("R7", "ceo_n follows ce_n low", {7'b0, a_ceo}, 8'd0);
    oe_line = 1'b1;
    #1 chk("R7", "ceo_n high on reset level", {7'b0, a_ceo}, 8'd1);
    step();
    oe_line = 1'b0;
    #1 chk("R7", "ceo_n stays high after reset", {7'b0, a_ceo}, 8'd1);
    chk_line("R3", 0, 0);
  endtask

  task automatic t_abort();
    ce_n = 1'b0;
    restart();
    repeat (37) step();
    #1 chk_line("R1", 0, 37);
    oe_line = 1'b1;
    #1 chk_line("R3", 2, 0);
    step();
    oe_line = 1'b0;
    #1 chk_line("R3", 0, 0);
    step();
    #1 chk_line("R3", 0, 1);
  endtask

  task automatic t_pol();
    ce_n = 1'b0;
    restart();
    repeat (DEPTH + 10) step();
    #1 chk_line("R4", 1, 10);
    oe_line = 1'b1;
    #1 chk_line("R4", 2, 0);
    step();
    oe_line = 1'b0;
    #1 chk_line("R4", 0, 0);
    repeat (DEPTH) step();
    #1 chk_line("R4", 1, 0);
  endtask

  task automatic t_standby();
    ce_n = 1'b0;
    restart();
    repeat (5) step();
    ce_n = 1'b1;
    #1 chk_line("R5", 2, 0);
    repeat (3) step();
    #1 chk_line("R5", 2, 0);
    ce_n = 1'b0;
    #1 chk_line("R5", 0, 5);
    step();
    #1 chk_line("R5", 0, 6);
  endtask

  task automatic t_prog();
    ce_n = 1'b0;
    restart();
    repeat (9) step();
    ser_en = 1'b0;
    oe_line = 1'b1;
    #1 chk_line("R9", 2, 0);
    chk("R9", "ceo_n in programming mode", {7'b0, a_ceo}, 8'd1);
    repeat (3) step();
    ser_en = 1'b1;
    oe_line = 1'b0;
    #1 chk_line("R9", 0, 9);
    step();
    #1 chk_line("R9", 0, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    t_reset();
    t_chain();
    t_follow();
    t_abort();
    t_pol();
    t_standby();
    t_prog();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule